// File: doc/BRIEF.md
# Register file read decoder

This block forms the read side of a small 8-bit controller's data memory. Each cycle it takes a register address and works out where the byte comes from. The possible sources are a fixed special register, one of two I/O ports, or general-purpose RAM behind a synchronous read port. Address zero is an indirect slot: the block replaces it with the contents of the file select register, masked to the implemented RAM range, and then decodes that address instead. A few locations are visible from both banks. High-bank addresses for those locations reach the low-bank copy in RAM.

Every source has the same latency. The selected special value is registered, and the RAM read port also returns its data one cycle later. So `rd_data` always reflects the address presented on the previous clock edge. Port reads mix live pin levels with output latch values per bit, controlled by the direction registers.

Top module: `mcu_file_read`

## Requirements
- R1: When `rd_addr` is 0x00, the address used for the read is `fsr & RAM_MASK` (default mask 0x7F), and that resolved address is then decoded in the same way as a direct address.
- R2: A resolved address of 0x00 or 0x80 reads as 0x00.
- R3: A resolved address of 0x04 or 0x84 reads `fsr | ~RAM_MASK`, so FSR bits outside the mask read as one.
- R4: Port reads take bit i from the pin when direction bit i is 1 and from the output latch when it is 0. Port B is read at 0x06.
- R5: Port A is read at 0x05. It has 5 bits, and bits 7..5 of its read value are 0.
- R6: Resolved addresses 0x82, 0x83 and 0x8B read RAM at 0x02, 0x03 and 0x0B. Addresses 0x02, 0x03 and 0x0B read RAM at the same address.
- R7: `pclath` reads at 0x0A and 0x8A, and `option` reads at 0x81. Direction A reads at 0x85, zero-extended above bit 4, and direction B reads at 0x86.
- R8: Any other resolved address is driven on `ram_addr` in the same cycle. The byte returned on `ram_rdata` one cycle later appears on `rd_data`. Direct addresses are not masked.
- R9: `rd_data` reflects the inputs sampled at the previous rising edge for every source, including back-to-back changes of source. While reset is held, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_addr | input | 8 | Register address to read |
| fsr | input | 8 | File select register value |
| pin_a | input | 5 | Port A pin levels |
| lat_a | input | 5 | Port A output latch |
| dir_a | input | 5 | Port A direction, 1 = input |
| pin_b | input | 8 | Port B pin levels |
| lat_b | input | 8 | Port B output latch |
| dir_b | input | 8 | Port B direction, 1 = input |
| pclath | input | 8 | Program counter high latch |
| option | input | 8 | Option register |
| ram_addr | output | 8 | Synchronous RAM read address |
| ram_rdata | input | 8 | RAM data, one cycle after address |
| rd_data | output | 8 | Read result |

## Verification
The bench probes the indirect slot with FSR values whose top bit is set. One of them masks down to zero, one lands on the FSR location itself, and others land on a port or on RAM. A design that skipped the mask or decoded the raw address would return the wrong byte. High-bank addresses are checked two ways: mirrored addresses must reach the low-bank copy, while unmirrored ones such as 0xA0 must not. This catches a design that drops bit 7 everywhere, and also one that never drops it. Port patterns use a different direction value on each bit, so a pin/latch swap or a missing port A clear shows up. Back-to-back sequences alternating RAM and special sources expose any mismatch in latency between the two paths.

// File: rtl/mcu_file_pkg.sv
package mcu_file_pkg;
   typedef enum logic [3:0] {
      SRC_ZERO,
      SRC_FSR,
      SRC_PORTA,
      SRC_PORTB,
      SRC_PCLATH,
      SRC_OPTION,
      SRC_DIRA,
      SRC_DIRB,
      SRC_RAM
   } rd_src_e;
endpackage

// File: rtl/mcu_addr_resolve.sv
module mcu_addr_resolve
   import mcu_file_pkg::*;
#(
   parameter int              AW       = 8,
   parameter logic [AW-1:0]   RAM_MASK = 8'h7F
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] fsr,
   output logic [AW-1:0] ram_addr,
   output rd_src_e       src
);
   localparam int BANK_BIT = AW - 1;

   logic [AW-1:0] eff;

   initial assert (AW == 8) else $error("address width must be 8");

   always_comb begin
      eff      = (addr == '0) ? (fsr & RAM_MASK) : addr;
      ram_addr = eff;
      src      = SRC_RAM;
      case (eff)
         8'h00, 8'h80: src = SRC_ZERO;
         8'h04, 8'h84: src = SRC_FSR;
         8'h05:        src = SRC_PORTA;
         8'h06:        src = SRC_PORTB;
         8'h0A, 8'h8A: src = SRC_PCLATH;
         8'h81:        src = SRC_OPTION;
         8'h85:        src = SRC_DIRA;
         8'h86:        src = SRC_DIRB;
         8'h82, 8'h83, 8'h8B: ram_addr[BANK_BIT] = 1'b0;
         default:      src = SRC_RAM;
      endcase
   end
endmodule

// File: rtl/mcu_port_merge.sv
module mcu_port_merge #(
   parameter int W     = 8,
   parameter int OUT_W = 8
) (
   input  logic [W-1:0]     pin,
   input  logic [W-1:0]     lat,
   input  logic [W-1:0]     dir,
   output logic [OUT_W-1:0] merged
);
   initial assert (W <= OUT_W && W > 0) else $error("port width out of range");

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign merged[i] = dir[i] ? pin[i] : lat[i];
   end

   if (OUT_W > W) begin : g_pad
      assign merged[OUT_W-1:W] = '0;
   end
endmodule

// File: rtl/mcu_file_read.sv
module mcu_file_read
   import mcu_file_pkg::*;
#(
   parameter int            DATA_W   = 8,
   parameter int            PA_W     = 5,
   parameter int            PB_W     = 8,
   parameter logic [7:0]    RAM_MASK = 8'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] fsr,
   input  logic [PA_W-1:0]   pin_a,
   input  logic [PA_W-1:0]   lat_a,
   input  logic [PA_W-1:0]   dir_a,
   input  logic [PB_W-1:0]   pin_b,
   input  logic [PB_W-1:0]   lat_b,
   input  logic [PB_W-1:0]   dir_b,
   input  logic [DATA_W-1:0] pclath,
   input  logic [DATA_W-1:0] option,
   output logic [DATA_W-1:0] ram_addr,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [DATA_W-1:0] HIGH_ONES = ~RAM_MASK;

   initial assert (DATA_W == 8) else $error("data width must be 8");
   initial assert (PA_W <= DATA_W && PB_W <= DATA_W) else $error("port wider than data");

   rd_src_e           src;
   logic [DATA_W-1:0] port_a_val;
   logic [DATA_W-1:0] port_b_val;
   logic [DATA_W-1:0] sfr_val;
   logic [DATA_W-1:0] sfr_q;
   logic              sel_ram_q;

   mcu_addr_resolve #(.AW(DATA_W), .RAM_MASK(RAM_MASK)) u_resolve (
      .addr     (rd_addr),
      .fsr      (fsr),
      .ram_addr (ram_addr),
      .src      (src)
   );

   mcu_port_merge #(.W(PA_W), .OUT_W(DATA_W)) u_port_a (
      .pin (pin_a), .lat (lat_a), .dir (dir_a), .merged (port_a_val)
   );

   mcu_port_merge #(.W(PB_W), .OUT_W(DATA_W)) u_port_b (
      .pin (pin_b), .lat (lat_b), .dir (dir_b), .merged (port_b_val)
   );

   always_comb begin
      case (src)
         SRC_FSR:    sfr_val = fsr | HIGH_ONES;
         SRC_PORTA:  sfr_val = port_a_val;
         SRC_PORTB:  sfr_val = port_b_val;
         SRC_PCLATH: sfr_val = pclath;
         SRC_OPTION: sfr_val = option;
         SRC_DIRA:   sfr_val = DATA_W'(dir_a);
         SRC_DIRB:   sfr_val = DATA_W'(dir_b);
         default:    sfr_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sfr_q     <= '0;
         sel_ram_q <= 1'b0;
      end else begin
         sfr_q     <= sfr_val;
         sel_ram_q <= (src == SRC_RAM);
      end
   end

   assign rd_data = sel_ram_q ? ram_rdata : sfr_q;

   // R1: the indirect slot never reaches past the RAM mask
   a_r1_indirect_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == '0) |-> ((ram_addr & ~RAM_MASK) == '0));

   // R2: the zero slots read back as zero one cycle later
   a_r2_zero_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_ZERO) |=> (rd_data == '0));

   // R3: FSR read shows the bits outside the mask as one
   a_r3_fsr_high_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_FSR) |=> ((rd_data & HIGH_ONES) == HIGH_ONES));

   // R6: mirrored high-bank locations reach the low-bank RAM copy
   a_r6_mirror_low_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 8'h82 || rd_addr == 8'h83 || rd_addr == 8'h8B)
      |-> (ram_addr == {1'b0, rd_addr[6:0]}));

   // R8: a RAM-selected read passes the returned byte through
   a_r8_ram_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_RAM) |=> (rd_data == ram_rdata));

   if (PA_W < DATA_W) begin : g_pa_chk
      // R5: upper bits of port A stay clear
      a_r5_porta_upper: assert property (@(posedge clk) disable iff (!rst_n)
         (src == SRC_PORTA) |=> (rd_data[DATA_W-1:PA_W] == '0));
   end
endmodule

// File: tb/mcu_file_read_bench.sv
module mcu_file_read_bench;
   localparam logic [7:0] MASK = 8'h7F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rd_addr = '0, fsr = '0, pin_b = '0, lat_b = '0, dir_b = '0;
   logic [4:0] pin_a = '0, lat_a = '0, dir_a = '0;
   logic [7:0] pclath = '0, option = '0;
   logic [7:0] ram_addr, ram_rdata, rd_data;
   logic [7:0] mem [256];

   int  checks = 0;
   int  fails = 0;
   bit  done = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2 clk = ~clk;

   mcu_file_read u_mcu_file_read (
      .clk, .rst_n, .rd_addr, .fsr, .pin_a, .lat_a, .dir_a,
      .pin_b, .lat_b, .dir_b, .pclath, .option,
      .ram_addr, .ram_rdata, .rd_data
   );

   always @(posedge clk) ram_rdata <= mem[ram_addr];

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: rd_data=%02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model(logic [7:0] a);
      logic [7:0] e;
      e = (a == 8'h00) ? (fsr & MASK) : a;
      case (e)
         8'h00, 8'h80: return 8'h00;
         8'h04, 8'h84: return fsr | ~MASK;
         8'h05:        return {3'b000, (pin_a & dir_a) | (lat_a & ~dir_a)};
         8'h06:        return (pin_b & dir_b) | (lat_b & ~dir_b);
         8'h0A, 8'h8A: return pclath;
         8'h81:        return option;
         8'h85:        return {3'b000, dir_a};
         8'h86:        return dir_b;
         8'h82, 8'h83, 8'h8B: return mem[e & 8'h7F];
         default:      return mem[e];
      endcase
   endfunction

   task automatic issue(logic [7:0] a, logic [7:0] f, string tag);
      @(negedge clk);
      rd_addr = a;
      fsr     = f;
      exp_q.push_back(model(a));
      tag_q.push_back(tag);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      check("R9 reset", rd_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      pin_a = 5'b10101; lat_a = 5'b01110; dir_a = 5'b11000;
      pin_b = 8'hF0;    lat_b = 8'h3C;    dir_b = 8'hAA;
      pclath = 8'h1D;   option = 8'hC7;

      issue(8'h00, 8'h00, "R2 indirect zero");
      issue(8'h00, 8'h80, "R1 R2 masked to zero");
      issue(8'h80, 8'h12, "R2 direct 0x80");
      issue(8'h04, 8'h35, "R3 fsr low bank");
      issue(8'h84, 8'h35, "R3 fsr high bank");
      issue(8'h00, 8'h84, "R1 indirect to fsr");
      issue(8'h05, 8'h00, "R5 R4 port A");
      issue(8'h06, 8'h00, "R4 port B");
      issue(8'h00, 8'h86, "R1 indirect to port B");
      issue(8'h82, 8'h00, "R6 mirror 82");
      issue(8'h83, 8'h00, "R6 mirror 83");
      issue(8'h8B, 8'h00, "R6 mirror 8B");
      issue(8'h0B, 8'h00, "R6 low 0B");
      issue(8'h0A, 8'h00, "R7 pclath low");
      issue(8'h8A, 8'h00, "R7 pclath high");
      issue(8'h81, 8'h00, "R7 option");
      issue(8'h85, 8'h00, "R7 dir A");
      issue(8'h86, 8'h00, "R7 dir B");
      issue(8'h20, 8'h00, "R8 ram 20");
      issue(8'hA0, 8'h00, "R8 ram A0 unmasked");
      issue(8'hFF, 8'h00, "R8 ram FF");
      issue(8'h00, 8'hC0, "R1 indirect to ram 40");

      @(negedge clk);
      pin_a = 5'b01010; dir_a = 5'b00111; lat_a = 5'b11100;
      pin_b = 8'h0F;    dir_b = 8'h5A;    lat_b = 8'hC3;
      issue(8'h05, 8'h00, "R5 port A second pattern");
      issue(8'h06, 8'h00, "R4 port B second pattern");
      for (int k = 0; k < 6; k++) begin
         issue(8'h30 + 8'(k), 8'h00, "R9 back-to-back ram");
         issue(8'h81, 8'h00, "R9 back-to-back sfr");
      end
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: rd_data=%02h expected completion", rd_data);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule